// File: doc/BRIEF.md
# Processor-to-I/O-Port Window Bridge

This block sits between a 32-bit processor bus and a byte-addressed I/O port bus. It takes processor accesses that land in a fixed 8 MB window at 0x80000000 and turns each one into a single I/O port request. The port address comes from one of two mappings. In the contiguous mapping the low 16 bits of the window offset are the port address, which gives a flat 64 KB port space. In the sparse mapping only 32 ports appear in each 4 KB page of the window: the low 5 offset bits are kept, and offset bits 22..12 are moved down to port bits 15..5. A level input from the control register file picks the mapping. The block reads that input when it accepts an access, so a change affects only later accesses.

A second window of 4 bytes at 0xBFFFFFF0 returns the pending interrupt vector. A read at byte 0 of this window returns the vector and sends a one-cycle acknowledge pulse to the interrupt controller. Reads at bytes 1 to 3 return zero, and writes anywhere in this window have no effect. An access that hits neither window is answered with the claimed flag low and causes no I/O cycle.

The request, response and I/O request channels use valid/ready. A sender keeps valid and its payload steady until ready is seen high at a clock edge. The block takes a new processor request only when it is idle, so one access is in flight at a time. The block holds its response until cpu_rsp_ready is high. The I/O read data arrives on a valid-only strobe and cannot be back-pressured. It must come at least one cycle after the I/O request handshake. Access size, data and write direction are passed through unchanged, in little-endian byte order.

Top module: `cpu_io_window_bridge`

## Requirements
- R1: An access with address in [0x80000000, 0x80800000) produces exactly one I/O request and a response with cpu_rsp_claimed = 1.
- R2: With map_noncontig = 0, io_req_port equals (address − 0x80000000) AND 0xFFFF.
- R3: With map_noncontig = 1, io_req_port equals (offset AND 0x1F) OR ((offset AND 0x7FF000) >> 7), where offset = address − 0x80000000; offset bits 11..5 are dropped.
- R4: map_noncontig is sampled on the cycle the request is accepted; changing it afterwards does not alter the port of that access.
- R5: A read at 0xBFFFFFF0 returns irq_vector, zero-extended and sampled at acceptance. irq_ack is high for exactly the one cycle after acceptance, while the claimed response is presented.
- R6: Reads at 0xBFFFFFF1 to 0xBFFFFFF3 return 0, are claimed, and raise no irq_ack.
- R7: Writes to 0xBFFFFFF0 to 0xBFFFFFF3 are claimed and return rdata 0. They produce no I/O request and no irq_ack.
- R8: An access outside both windows gets a response with cpu_rsp_claimed = 0 and rdata 0, and produces no I/O request.
- R9: io_req_size (00 byte, 01 halfword, 10 word), io_req_write and io_req_wdata equal the accepted request's values. The read data of an I/O read equals io_rsp_rdata.
- R10: cpu_req_ready is low from acceptance until the response is taken. The io_req payload and the cpu_rsp payload stay stable while their valid is high and ready is low.
- R11: After reset, cpu_req_ready = 1 and cpu_rsp_valid, io_req_valid and irq_ack are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_noncontig | input | 1 | 0 = contiguous 64 KB mapping, 1 = sparse 32-ports-per-page mapping |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Block can accept a request (idle) |
| cpu_req_addr | input | 32 | Processor byte address |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_req_wdata | input | 32 | Write data, little-endian |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | 32 | Read data (0 for writes) |
| cpu_rsp_claimed | output | 1 | 1 when the access hit a window |
| io_req_valid | output | 1 | I/O request valid |
| io_req_ready | input | 1 | I/O bus takes the request |
| io_req_port | output | 16 | Translated port address |
| io_req_write | output | 1 | I/O write direction |
| io_req_size | output | 2 | Access size, passed through |
| io_req_wdata | output | 32 | Write data, passed through |
| io_rsp_valid | input | 1 | I/O read data strobe |
| io_rsp_rdata | input | 32 | I/O read data |
| irq_vector | input | 8 | Pending vector from the interrupt controller |
| irq_ack | output | 1 | One-cycle acknowledge pulse |

## Verification
Results for interrupt-acknowledge and unclaimed accesses are due one cycle after the accepting edge. At that point the response is valid, and irq_ack is high for byte-0 reads only. An I/O request is valid one cycle after acceptance. A write's response follows one cycle after the I/O handshake, and a read's response follows one cycle after the io_rsp_valid strobe. The bench drives each input on a falling edge, waits for the rising edge that consumes it, and samples on the next falling edge. It also holds each ready low for extra cycles to confirm the payload stays stable. A falling-edge monitor flags any io_req_valid outside an expected I/O access and counts irq_ack pulses. The bench compares that count with the expected pulses after each access.

// File: rtl/iow_pkg.sv
package iow_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_IO_REQ,
    ST_IO_WAIT,
    ST_RESP
  } iow_state_e;

  typedef enum logic [1:0] {
    HIT_NONE,
    HIT_IO,
    HIT_ACK
  } iow_hit_e;

  localparam logic [1:0] SIZE_BYTE = 2'b00;
  localparam logic [1:0] SIZE_HALF = 2'b01;
  localparam logic [1:0] SIZE_WORD = 2'b10;
endpackage

// File: rtl/iow_decode.sv
module iow_decode
  import iow_pkg::*;
#(
  parameter int               ADDR_W    = 32,
  parameter int               WIN_LOG2  = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
  parameter int               ACK_LOG2  = 2,
  parameter logic [ADDR_W-1:0] ACK_BASE = 32'hBFFF_FFF0,
  parameter int               VSEL_LOG2 = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  output iow_hit_e            hit,
  output logic                vec_sel,
  output logic [WIN_LOG2-1:0] offset
);
  logic in_io;
  logic in_ack;

  // both windows are aligned to their own size, so a compare of the upper bits suffices
  assign in_io   = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign in_ack  = (addr[ADDR_W-1:ACK_LOG2] == ACK_BASE[ADDR_W-1:ACK_LOG2]);
  assign vec_sel = (addr[VSEL_LOG2-1:0] == '0);
  assign offset  = addr[WIN_LOG2-1:0];

  always_comb begin
    if (in_io)       hit = HIT_IO;
    else if (in_ack) hit = HIT_ACK;
    else             hit = HIT_NONE;
  end
endmodule

// File: rtl/iow_port_map.sv
module iow_port_map #(
  parameter int WIN_LOG2  = 23,
  parameter int PORT_W    = 16,
  parameter int PAGE_LOG2 = 12,
  parameter int KEEP_LOG2 = 5
) (
  input  logic [WIN_LOG2-1:0] offset,
  input  logic                sparse,
  output logic [PORT_W-1:0]   port
);
  localparam int PAGE_BITS = WIN_LOG2 - PAGE_LOG2;
  localparam int SPARSE_W  = PAGE_BITS + KEEP_LOG2;

  logic [PORT_W-1:0]   flat_port;
  logic [PORT_W-1:0]   sparse_port;
  logic [SPARSE_W-1:0] packed_sparse;

  assign flat_port     = offset[PORT_W-1:0];
  // page number lands directly above the kept in-page bits
  assign packed_sparse = {offset[WIN_LOG2-1:PAGE_LOG2], offset[KEEP_LOG2-1:0]};

  generate
    if (PORT_W > SPARSE_W) begin : g_pad
      assign sparse_port = {{(PORT_W-SPARSE_W){1'b0}}, packed_sparse};
    end else begin : g_trim
      assign sparse_port = packed_sparse[PORT_W-1:0];
    end
  endgenerate

  assign port = sparse ? sparse_port : flat_port;
endmodule

// File: rtl/cpu_io_window_bridge.sv
module cpu_io_window_bridge
  import iow_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                PORT_W    = 16,
  parameter int                VEC_W     = 8,
  parameter int                WIN_LOG2  = 23,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
  parameter int                ACK_LOG2  = 2,
  parameter logic [ADDR_W-1:0] ACK_BASE  = 32'hBFFF_FFF0,
  parameter int                PAGE_LOG2 = 12,
  parameter int                KEEP_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_noncontig,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic              cpu_req_write,
  input  logic [1:0]        cpu_req_size,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              cpu_rsp_claimed,
  output logic              io_req_valid,
  input  logic              io_req_ready,
  output logic [PORT_W-1:0] io_req_port,
  output logic              io_req_write,
  output logic [1:0]        io_req_size,
  output logic [DATA_W-1:0] io_req_wdata,
  input  logic              io_rsp_valid,
  input  logic [DATA_W-1:0] io_rsp_rdata,
  input  logic [VEC_W-1:0]  irq_vector,
  output logic              irq_ack
);
  localparam int VEC_PAD = DATA_W - VEC_W;

  iow_state_e          st_q;
  iow_hit_e            hit;
  logic                vec_sel;
  logic [WIN_LOG2-1:0] offset;
  logic [PORT_W-1:0]   mapped_port;

  logic [PORT_W-1:0]   port_q;
  logic                wr_q;
  logic [1:0]          size_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                claimed_q;
  logic                ack_q;

  iow_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .WIN_BASE (WIN_BASE),
    .ACK_LOG2 (ACK_LOG2),
    .ACK_BASE (ACK_BASE),
    .VSEL_LOG2(4)
  ) u_decode (
    .addr   (cpu_req_addr),
    .hit    (hit),
    .vec_sel(vec_sel),
    .offset (offset)
  );

  iow_port_map #(
    .WIN_LOG2 (WIN_LOG2),
    .PORT_W   (PORT_W),
    .PAGE_LOG2(PAGE_LOG2),
    .KEEP_LOG2(KEEP_LOG2)
  ) u_port_map (
    .offset(offset),
    .sparse(map_noncontig),
    .port  (mapped_port)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      port_q    <= '0;
      wr_q      <= 1'b0;
      size_q    <= SIZE_BYTE;
      wdata_q   <= '0;
      rdata_q   <= '0;
      claimed_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            // the mapping mode is captured here, together with the address
            port_q    <= mapped_port;
            wr_q      <= cpu_req_write;
            size_q    <= cpu_req_size;
            wdata_q   <= cpu_req_wdata;
            claimed_q <= (hit != HIT_NONE);
            rdata_q   <= '0;
            unique case (hit)
              HIT_IO:  st_q <= ST_IO_REQ;
              HIT_ACK: begin
                if (!cpu_req_write && vec_sel) begin
                  rdata_q <= {{VEC_PAD{1'b0}}, irq_vector};
                  ack_q   <= 1'b1;
                end
                st_q <= ST_RESP;
              end
              default: st_q <= ST_RESP;
            endcase
          end
        end
        ST_IO_REQ: begin
          if (io_req_ready) begin
            st_q <= wr_q ? ST_RESP : ST_IO_WAIT;
          end
        end
        ST_IO_WAIT: begin
          if (io_rsp_valid) begin
            rdata_q <= io_rsp_rdata;
            st_q    <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (cpu_rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_req_ready   = (st_q == ST_IDLE);
  assign cpu_rsp_valid   = (st_q == ST_RESP);
  assign cpu_rsp_rdata   = rdata_q;
  assign cpu_rsp_claimed = claimed_q;
  assign io_req_valid    = (st_q == ST_IO_REQ);
  assign io_req_port     = port_q;
  assign io_req_write    = wr_q;
  assign io_req_size     = size_q;
  assign io_req_wdata    = wdata_q;
  assign irq_ack         = ack_q;
endmodule

// File: rtl/iow_checker.sv
module iow_checker #(
  parameter int DATA_W = 32,
  parameter int PORT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              cpu_rsp_ready,
  input logic [DATA_W-1:0] cpu_rsp_rdata,
  input logic              cpu_rsp_claimed,
  input logic              io_req_valid,
  input logic              io_req_ready,
  input logic [PORT_W-1:0] io_req_port,
  input logic              io_req_write,
  input logic [1:0]        io_req_size,
  input logic [DATA_W-1:0] io_req_wdata,
  input logic              irq_ack
);
  // R10
  io_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_valid && !io_req_ready |=> io_req_valid && $stable(io_req_port)
      && $stable(io_req_write) && $stable(io_req_size) && $stable(io_req_wdata));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata)
      && $stable(cpu_rsp_claimed));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);

  // R5
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R5
  ack_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> cpu_rsp_valid && cpu_rsp_claimed);

  // R8
  unclaimed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_claimed |-> cpu_rsp_rdata == '0);

  // R1
  io_rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_req_valid |-> !cpu_rsp_valid && !cpu_req_ready);
endmodule

bind cpu_io_window_bridge iow_checker #(
  .DATA_W(DATA_W),
  .PORT_W(PORT_W)
) u_iow_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_req_valid  (cpu_req_valid),
  .cpu_req_ready  (cpu_req_ready),
  .cpu_rsp_valid  (cpu_rsp_valid),
  .cpu_rsp_ready  (cpu_rsp_ready),
  .cpu_rsp_rdata  (cpu_rsp_rdata),
  .cpu_rsp_claimed(cpu_rsp_claimed),
  .io_req_valid   (io_req_valid),
  .io_req_ready   (io_req_ready),
  .io_req_port    (io_req_port),
  .io_req_write   (io_req_write),
  .io_req_size    (io_req_size),
  .io_req_wdata   (io_req_wdata),
  .irq_ack        (irq_ack)
);

// File: tb/test_cpu_io_window_bridge.sv
`timescale 1ns/1ps
module test_cpu_io_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_noncontig = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic        cpu_req_ready;
  logic [31:0] cpu_req_addr = '0;
  logic        cpu_req_write = 1'b0;
  logic [1:0]  cpu_req_size = 2'b00;
  logic [31:0] cpu_req_wdata = '0;
  logic        cpu_rsp_valid;
  logic        cpu_rsp_ready = 1'b0;
  logic [31:0] cpu_rsp_rdata;
  logic        cpu_rsp_claimed;
  logic        io_req_valid;
  logic        io_req_ready = 1'b0;
  logic [15:0] io_req_port;
  logic        io_req_write;
  logic [1:0]  io_req_size;
  logic [31:0] io_req_wdata;
  logic        io_rsp_valid = 1'b0;
  logic [31:0] io_rsp_rdata = '0;
  logic [7:0]  irq_vector = 8'h00;
  logic        irq_ack;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int ack_cnt = 0;
  logic io_allowed = 1'b0;

  always #10 clk = ~clk;

  cpu_io_window_bridge i_cpu_io_window_bridge (
    .clk(clk), .rst_n(rst_n), .map_noncontig(map_noncontig),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_addr(cpu_req_addr), .cpu_req_write(cpu_req_write),
    .cpu_req_size(cpu_req_size), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_rdata(cpu_rsp_rdata), .cpu_rsp_claimed(cpu_rsp_claimed),
    .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_req_port(io_req_port), .io_req_write(io_req_write),
    .io_req_size(io_req_size), .io_req_wdata(io_req_wdata),
    .io_rsp_valid(io_rsp_valid), .io_rsp_rdata(io_rsp_rdata),
    .irq_vector(irq_vector), .irq_ack(irq_ack)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      finish_run();
    end
  end

  // per-cycle monitor: stray I/O requests (R7, R8) and acknowledge pulse count (R5)
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_ack) ack_cnt++;
      if (io_req_valid && !io_allowed)
        chk(1'b0, "R8", "unexpected io_req_valid", 32'(io_req_valid), 32'h0);
    end
  end

  // One processor access; caller starts at a falling edge.
  task automatic access(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                        input logic [31:0] wd, input int dly, input logic [31:0] iod,
                        input logic flip, input string req);
    logic        is_io, is_ack, want_ack;
    logic [31:0] off, erd;
    logic [15:0] eport;
    int          ack0;
    is_io    = (a >= 32'h8000_0000) && (a < 32'h8080_0000);
    is_ack   = (a >= 32'hBFFF_FFF0) && (a < 32'hBFFF_FFF4);
    want_ack = is_ack && !wr && (a[3:0] == 4'h0);
    off      = a - 32'h8000_0000;
    eport    = map_noncontig ? 16'((off & 32'h1F) | ((off & 32'h7FF000) >> 7))
                             : 16'(off & 32'hFFFF);
    erd      = 32'h0;
    if (is_io && !wr) erd = iod;
    if (want_ack)     erd = {24'h0, irq_vector};
    ack0 = ack_cnt;

    chk(cpu_req_ready == 1'b1, "R10", "ready before request", 32'(cpu_req_ready), 32'h1);
    cpu_req_addr  = a;
    cpu_req_write = wr;
    cpu_req_size  = sz;
    cpu_req_wdata = wd;
    cpu_req_valid = 1'b1;
    io_allowed    = is_io;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (flip) map_noncontig = ~map_noncontig;
    chk(cpu_req_ready == 1'b0, "R10", "ready while busy", 32'(cpu_req_ready), 32'h0);

    if (is_io) begin
      chk(io_req_valid == 1'b1, "R1", "io_req_valid", 32'(io_req_valid), 32'h1);
      chk(io_req_port == eport, req, "io_req_port", 32'(io_req_port), 32'(eport));
      chk(io_req_write == wr, "R9", "io_req_write", 32'(io_req_write), 32'(wr));
      chk(io_req_size == sz, "R9", "io_req_size", 32'(io_req_size), 32'(sz));
      chk(io_req_wdata == wd, "R9", "io_req_wdata", io_req_wdata, wd);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk(io_req_valid && io_req_port == eport, "R10", "io_req held",
            32'(io_req_port), 32'(eport));
      end
      io_req_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      io_req_ready = 1'b0;
      io_allowed   = 1'b0;
      if (!wr) begin
        chk(cpu_rsp_valid == 1'b0, "R9", "rsp before io data", 32'(cpu_rsp_valid), 32'h0);
        io_rsp_valid = 1'b1;
        io_rsp_rdata = iod;
        @(posedge clk);
        @(negedge clk);
        io_rsp_valid = 1'b0;
        io_rsp_rdata = 32'h0;
      end
    end else begin
      chk(io_req_valid == 1'b0, req, "no io request", 32'(io_req_valid), 32'h0);
      chk(irq_ack == want_ack, req, "irq_ack after accept", 32'(irq_ack), 32'(want_ack));
    end

    for (int i = 0; i < 20 && !cpu_rsp_valid; i++) @(negedge clk);
    chk(cpu_rsp_valid == 1'b1, req, "cpu_rsp_valid", 32'(cpu_rsp_valid), 32'h1);
    chk(cpu_rsp_rdata == erd, req, "cpu_rsp_rdata", cpu_rsp_rdata, erd);
    chk(cpu_rsp_claimed == (is_io || is_ack), req, "cpu_rsp_claimed",
        32'(cpu_rsp_claimed), 32'(is_io || is_ack));
    @(negedge clk);
    chk(cpu_rsp_valid && cpu_rsp_rdata == erd, "R10", "response held",
        cpu_rsp_rdata, erd);
    cpu_rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_rsp_ready = 1'b0;
    chk(!cpu_rsp_valid && cpu_req_ready, "R10", "idle after response",
        32'({cpu_rsp_valid, cpu_req_ready}), 32'h1);
    chk((ack_cnt - ack0) == int'(want_ack), want_ack ? "R5" : req, "irq_ack pulses",
        32'(ack_cnt - ack0), 32'(want_ack));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cpu_req_ready == 1'b1, "R11", "reset cpu_req_ready", 32'(cpu_req_ready), 32'h1);
    chk({cpu_rsp_valid, io_req_valid, irq_ack} == 3'b000, "R11", "reset valids",
        32'({cpu_rsp_valid, io_req_valid, irq_ack}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 contiguous mapping
    map_noncontig = 1'b0;
    access(32'h8000_0398, 1'b0, 2'b00, 32'h0, 0, 32'h0000_00A5, 1'b0, "R2");
    access(32'h807F_1234, 1'b1, 2'b10, 32'hDEAD_BEEF, 2, 32'h0, 1'b0, "R2");
    access(32'h8001_0092, 1'b0, 2'b01, 32'h0, 3, 32'h0000_5A3C, 1'b0, "R9");

    // R3 sparse mapping
    map_noncontig = 1'b1;
    access(32'h8001_2345, 1'b0, 2'b10, 32'h0, 1, 32'h1234_5678, 1'b0, "R3");
    access(32'h807F_F01F, 1'b1, 2'b00, 32'h0000_0077, 0, 32'h0, 1'b0, "R3");
    access(32'h8000_0FE0, 1'b1, 2'b01, 32'h0000_ABCD, 0, 32'h0, 1'b0, "R3");

    // R4 mode change right after acceptance affects only later accesses
    access(32'h8000_3031, 1'b0, 2'b00, 32'h0, 2, 32'h0000_0011, 1'b1, "R4");
    access(32'h8000_3031, 1'b0, 2'b00, 32'h0, 0, 32'h0000_0022, 1'b0, "R4");

    // R5 vector read, R6 other bytes, R7 writes
    irq_vector = 8'h2B;
    access(32'hBFFF_FFF0, 1'b0, 2'b00, 32'h0, 0, 32'h0, 1'b0, "R5");
    irq_vector = 8'hF7;
    access(32'hBFFF_FFF0, 1'b0, 2'b10, 32'h0, 0, 32'h0, 1'b0, "R5");
    access(32'hBFFF_FFF1, 1'b0, 2'b00, 32'h0, 0, 32'h0, 1'b0, "R6");
    access(32'hBFFF_FFF3, 1'b0, 2'b00, 32'h0, 0, 32'h0, 1'b0, "R6");
    access(32'hBFFF_FFF0, 1'b1, 2'b00, 32'h0000_00FF, 0, 32'h0, 1'b0, "R7");
    access(32'hBFFF_FFF2, 1'b1, 2'b01, 32'h0000_1234, 0, 32'h0, 1'b0, "R7");

    // R8 outside both windows, including the edges
    access(32'h7FFF_FFFF, 1'b0, 2'b00, 32'h0, 0, 32'h0, 1'b0, "R8");
    access(32'h8080_0000, 1'b1, 2'b10, 32'h1111_2222, 0, 32'h0, 1'b0, "R8");
    access(32'hBFFF_FFF4, 1'b0, 2'b00, 32'h0, 0, 32'h0, 1'b0, "R8");
    access(32'hBFFF_FFEF, 1'b0, 2'b00, 32'h0, 0, 32'h0, 1'b0, "R8");

    // R1 first and last byte of the I/O window
    map_noncontig = 1'b0;
    access(32'h8000_0000, 1'b0, 2'b00, 32'h0, 0, 32'h0000_0001, 1'b0, "R1");
    access(32'h807F_FFFF, 1'b0, 2'b00, 32'h0, 0, 32'h0000_0002, 1'b0, "R1");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule